// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block is the working register array of a small 8-bit RISC core: 32 registers of 8 bits, each read or written in one clock cycle. Two 8-bit read ports and a 16-bit read port that fetches an aligned register pair feed the datapath. A write port stores either one byte or an aligned pair. Together these ports cover every operand shape an 8-bit datapath needs: one or two byte operands, and byte or word results.

The six highest registers double as three 16-bit address pointers. A pointer port forms a data-space address from a selected pointer, either as it is, plus a small displacement, with post-increment, or with pre-decrement. The updated pointer is written back at the same clock edge. The registers also appear at the bottom of the data space, so an address from any source that decodes below 0x20 is served by the array. The block flags addresses in the I/O window that follows the registers.

Top module: `rfp_regfile`

## Requirements
- R1: After reset every one of the 32 registers reads as zero.
- R2: Read ports A and B return the current content of the register their index selects, without a clock. A write lands at the next rising edge, so a read of the register being written in the same cycle returns the old value.
- R3: The 16-bit read returns register (rd_a_idx with bit 0 set) in bits 15:8 and register (rd_a_idx with bit 0 cleared) in bits 7:0. Bit 0 of the index is ignored.
- R4: With wr_en=1 and wr_wide=0, wr_data[7:0] is stored into register wr_idx.
- R5: With wr_en=1 and wr_wide=1 and an even wr_idx, wr_data[7:0] goes to wr_idx and wr_data[15:8] to wr_idx+1. An odd wr_idx with wr_wide=1 changes no register.
- R6: ptr_sel 0, 1 and 2 pick the pairs 26/27, 28/29 and 30/31, and the lower-numbered register is the low byte. ptr_sel 3 gives ptr_addr 0 and updates nothing.
- R7: In ptr_mode 0, ptr_addr is the pointer. In ptr_mode 1, ptr_addr is the pointer plus the zero-extended 6-bit ptr_disp. Neither mode changes the pointer.
- R8: In ptr_mode 2, ptr_addr is the old pointer, and with ptr_en=1 the pointer becomes old+1, modulo 2^16.
- R9: In ptr_mode 3, ptr_addr is the pointer minus one, and with ptr_en=1 the pointer becomes that same value, modulo 2^16.
- R10: For ds_addr 0x0000–0x001F, ds_hit_reg=1 and ds_rdata is register ds_addr. For ds_addr 0x0020–0x005F, ds_hit_io=1. In every other case the flag is 0, and ds_rdata is 0 whenever ds_hit_reg is 0.
- R11: ds_we=1 with ds_hit_reg=1 stores ds_wdata into register ds_addr. ds_we=1 at any other address changes no register.
- R12: When several writes reach one register byte in the same cycle, the write port wins over a data-space write, and a data-space write wins over a pointer write-back. Each byte is resolved on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A index, also the pair index for the wide read |
| rd_b_idx | input | 5 | Read port B index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_data | output | 8 | Read port B data |
| rd_w_data | output | 16 | Aligned pair read |
| wr_en | input | 1 | Write port enable |
| wr_wide | input | 1 | 1: pair write, 0: byte write |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 16 | Write data, byte writes use bits 7:0 |
| ptr_en | input | 1 | Allow pointer write-back |
| ptr_sel | input | 2 | Pointer select, 3 = none |
| ptr_mode | input | 2 | 0 plain, 1 displacement, 2 post-increment, 3 pre-decrement |
| ptr_disp | input | 6 | Displacement for mode 1 |
| ptr_addr | output | 16 | Effective data-space address |
| ds_addr | input | 16 | Data-space address to decode |
| ds_we | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Register content when the address hits the array |
| ds_hit_reg | output | 1 | Address falls on the register array |
| ds_hit_io | output | 1 | Address falls in the I/O window |

## Verification
A pointer write-back and a direct write can target the same register pair in one clock. This happens, for example, when a post-increment on a pointer coincides with a byte write to its low register or with a data-space store into its high register. Directed cases set up exactly this overlap, and the random phase produces it often by drawing the write index and the pointer select from small ranges. After each edge, every byte is compared with a reference model that applies the three writers in ascending priority, so one byte can come from the pointer arithmetic while its partner comes from the write port.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

   // addressing modes of the pointer port
   typedef enum logic [1:0] {
      PM_PLAIN   = 2'd0,
      PM_DISP    = 2'd1,
      PM_POSTINC = 2'd2,
      PM_PREDEC  = 2'd3
   } ptr_mode_e;

endpackage

// File: rtl/rfp_ptr_unit.sv
module rfp_ptr_unit
   import rfp_pkg::*;
#(
   parameter int unsigned PW    = 16,
   parameter int unsigned DISPW = 6
)(
   input  logic             ptr_valid,
   input  logic             ptr_en,
   input  logic [1:0]       ptr_mode,
   input  logic [DISPW-1:0] ptr_disp,
   input  logic [PW-1:0]    ptr_q,
   output logic [PW-1:0]    addr,
   output logic             wb_en,
   output logic [PW-1:0]    wb_val
);

   logic [PW-1:0] inc_val;
   logic [PW-1:0] dec_val;
   logic [PW-1:0] disp_val;
   ptr_mode_e     mode;

   assign inc_val  = ptr_q + PW'(1);
   assign dec_val  = ptr_q - PW'(1);
   assign disp_val = ptr_q + PW'(ptr_disp);
   assign mode     = ptr_mode_e'(ptr_mode);

   always_comb begin
      addr   = '0;
      wb_en  = 1'b0;
      wb_val = ptr_q;
      if (ptr_valid) begin
         unique case (mode)
            PM_PLAIN:   addr = ptr_q;
            PM_DISP:    addr = disp_val;
            PM_POSTINC: begin
               addr   = ptr_q;
               wb_en  = ptr_en;
               wb_val = inc_val;
            end
            PM_PREDEC:  begin
               addr   = dec_val;
               wb_en  = ptr_en;
               wb_val = dec_val;
            end
            default:    addr = ptr_q;
         endcase
      end
   end

endmodule

// File: rtl/rfp_ds_decode.sv
module rfp_ds_decode #(
   parameter int unsigned AW      = 16,
   parameter int unsigned NREGS   = 32,
   parameter int unsigned IO_SPAN = 64
)(
   input  logic [AW-1:0]              ds_addr,
   output logic                       hit_reg,
   output logic                       hit_io,
   output logic [$clog2(NREGS)-1:0]   reg_idx
);

   localparam int unsigned IDXW   = $clog2(NREGS);
   localparam logic [AW-1:0] REG_END = AW'(NREGS);
   localparam logic [AW-1:0] IO_END  = AW'(NREGS + IO_SPAN);

   if (AW <= IDXW) begin : g_bad_aw
      $error("rfp_ds_decode: address width must exceed register index width");
   end

   assign hit_reg = (ds_addr < REG_END);
   assign hit_io  = (ds_addr >= REG_END) && (ds_addr < IO_END);
   assign reg_idx = ds_addr[IDXW-1:0];

endmodule

// File: rtl/rfp_write_merge.sv
module rfp_write_merge #(
   parameter int unsigned DW       = 8,
   parameter int unsigned NREGS    = 32,
   parameter int unsigned PTR_BASE = 26,
   parameter int unsigned NPTR     = 3,
   parameter int unsigned SELW     = 2
)(
   input  logic                         wr_en,
   input  logic                         wr_wide,
   input  logic [$clog2(NREGS)-1:0]     wr_idx,
   input  logic [2*DW-1:0]              wr_data,
   input  logic                         ds_we,
   input  logic [$clog2(NREGS)-1:0]     ds_idx,
   input  logic [DW-1:0]                ds_wdata,
   input  logic                         ptr_wb_en,
   input  logic [SELW-1:0]              ptr_sel,
   input  logic [2*DW-1:0]              ptr_wb_val,
   output logic [NREGS-1:0]             we,
   output logic [NREGS-1:0][DW-1:0]     wd
);

   localparam int unsigned IDXW = $clog2(NREGS);
   localparam int unsigned PW   = 2*DW;

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      localparam bit IS_HI  = (i % 2) == 1;
      localparam bit IN_PTR = (i >= int'(PTR_BASE)) && (i < int'(PTR_BASE + 2*NPTR));

      logic          wr_hit;
      logic          ds_hit;
      logic          ptr_hit;
      logic [DW-1:0] wr_byte;
      logic [DW-1:0] ptr_byte;

      always_comb begin
         if (wr_wide) begin
            wr_hit  = wr_en && !wr_idx[0] && (wr_idx[IDXW-1:1] == (IDXW-1)'(i/2));
            wr_byte = IS_HI ? wr_data[PW-1:DW] : wr_data[DW-1:0];
         end else begin
            wr_hit  = wr_en && (wr_idx == IDXW'(i));
            wr_byte = wr_data[DW-1:0];
         end
         ds_hit = ds_we && (ds_idx == IDXW'(i));
      end

      if (IN_PTR) begin : g_ptr
         assign ptr_hit  = ptr_wb_en && (ptr_sel == SELW'((i - int'(PTR_BASE)) / 2));
         assign ptr_byte = IS_HI ? ptr_wb_val[PW-1:DW] : ptr_wb_val[DW-1:0];
      end else begin : g_plain
         assign ptr_hit  = 1'b0;
         assign ptr_byte = '0;
      end

      // byte-wise priority: write port, then data space, then pointer
      assign we[i] = wr_hit | ds_hit | ptr_hit;
      assign wd[i] = wr_hit ? wr_byte : (ds_hit ? ds_wdata : ptr_byte);
   end

endmodule

// File: rtl/rfp_regfile.sv
module rfp_regfile #(
   parameter int unsigned DW       = 8,
   parameter int unsigned NREGS    = 32,
   parameter int unsigned PTR_BASE = 26,
   parameter int unsigned NPTR     = 3,
   parameter int unsigned DISPW    = 6,
   parameter int unsigned IO_SPAN  = 64
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [$clog2(NREGS)-1:0]     rd_a_idx,
   input  logic [$clog2(NREGS)-1:0]     rd_b_idx,
   output logic [DW-1:0]                rd_a_data,
   output logic [DW-1:0]                rd_b_data,
   output logic [2*DW-1:0]              rd_w_data,
   input  logic                         wr_en,
   input  logic                         wr_wide,
   input  logic [$clog2(NREGS)-1:0]     wr_idx,
   input  logic [2*DW-1:0]              wr_data,
   input  logic                         ptr_en,
   input  logic [$clog2(NPTR+1)-1:0]    ptr_sel,
   input  logic [1:0]                   ptr_mode,
   input  logic [DISPW-1:0]             ptr_disp,
   output logic [2*DW-1:0]              ptr_addr,
   input  logic [2*DW-1:0]              ds_addr,
   input  logic                         ds_we,
   input  logic [DW-1:0]                ds_wdata,
   output logic [DW-1:0]                ds_rdata,
   output logic                         ds_hit_reg,
   output logic                         ds_hit_io
);

   localparam int unsigned IDXW = $clog2(NREGS);
   localparam int unsigned PW   = 2*DW;
   localparam int unsigned SELW = $clog2(NPTR+1);

   // elaboration-time parameter checks
   if ((1 << IDXW) != NREGS) begin : g_bad_depth
      $error("rfp_regfile: NREGS must be a power of two");
   end
   if ((PTR_BASE % 2) != 0 || (PTR_BASE + 2*NPTR) > NREGS) begin : g_bad_ptr
      $error("rfp_regfile: pointer pairs must be aligned and inside the array");
   end
   if (DISPW >= PW) begin : g_bad_disp
      $error("rfp_regfile: displacement must be narrower than a pointer");
   end

   logic [NREGS-1:0][DW-1:0] regs_q;
   logic [NREGS-1:0]         we;
   logic [NREGS-1:0][DW-1:0] wd;

   // ---------------- read ports ----------------
   logic [IDXW-1:0] rw_lo_idx;
   logic [IDXW-1:0] rw_hi_idx;

   assign rw_lo_idx = {rd_a_idx[IDXW-1:1], 1'b0};
   assign rw_hi_idx = {rd_a_idx[IDXW-1:1], 1'b1};
   assign rd_a_data = regs_q[rd_a_idx];
   assign rd_b_data = regs_q[rd_b_idx];
   assign rd_w_data = {regs_q[rw_hi_idx], regs_q[rw_lo_idx]};

   // ---------------- pointer port ----------------
   logic            ptr_valid;
   logic [IDXW-1:0] plo_idx;
   logic [IDXW-1:0] phi_idx;
   logic [PW-1:0]   ptr_q;
   logic            ptr_wb_en;
   logic [PW-1:0]   ptr_wb_val;

   assign ptr_valid = (ptr_sel < SELW'(NPTR));
   assign plo_idx   = IDXW'(PTR_BASE + 2*int'(ptr_sel));
   assign phi_idx   = {plo_idx[IDXW-1:1], 1'b1};
   assign ptr_q     = {regs_q[phi_idx], regs_q[plo_idx]};

   rfp_ptr_unit #(
      .PW    (PW),
      .DISPW (DISPW)
   ) i_ptr (
      .ptr_valid (ptr_valid),
      .ptr_en    (ptr_en),
      .ptr_mode  (ptr_mode),
      .ptr_disp  (ptr_disp),
      .ptr_q     (ptr_q),
      .addr      (ptr_addr),
      .wb_en     (ptr_wb_en),
      .wb_val    (ptr_wb_val)
   );

   // ---------------- data-space window ----------------
   logic [IDXW-1:0] ds_idx;

   rfp_ds_decode #(
      .AW      (PW),
      .NREGS   (NREGS),
      .IO_SPAN (IO_SPAN)
   ) i_dsdec (
      .ds_addr (ds_addr),
      .hit_reg (ds_hit_reg),
      .hit_io  (ds_hit_io),
      .reg_idx (ds_idx)
   );

   assign ds_rdata = ds_hit_reg ? regs_q[ds_idx] : '0;

   // ---------------- write merge and storage ----------------
   rfp_write_merge #(
      .DW       (DW),
      .NREGS    (NREGS),
      .PTR_BASE (PTR_BASE),
      .NPTR     (NPTR),
      .SELW     (SELW)
   ) i_merge (
      .wr_en      (wr_en),
      .wr_wide    (wr_wide),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .ds_we      (ds_we && ds_hit_reg),
      .ds_idx     (ds_idx),
      .ds_wdata   (ds_wdata),
      .ptr_wb_en  (ptr_wb_en),
      .ptr_sel    (ptr_sel),
      .ptr_wb_val (ptr_wb_val),
      .we         (we),
      .wd         (wd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else begin
         for (int i = 0; i < int'(NREGS); i++) begin
            if (we[i]) regs_q[i] <= wd[i];
         end
      end
   end

endmodule

// File: rtl/rfp_checker.sv
module rfp_checker #(
   parameter int unsigned DW       = 8,
   parameter int unsigned NREGS    = 32,
   parameter int unsigned PTR_BASE = 26,
   parameter int unsigned NPTR     = 3
)(
   input logic                          clk,
   input logic                          rst_n,
   input logic [$clog2(NREGS)-1:0]      rd_a_idx,
   input logic [DW-1:0]                 rd_a_data,
   input logic                          wr_en,
   input logic                          wr_wide,
   input logic [$clog2(NREGS)-1:0]      wr_idx,
   input logic [2*DW-1:0]               wr_data,
   input logic                          ptr_en,
   input logic [$clog2(NPTR+1)-1:0]     ptr_sel,
   input logic [1:0]                    ptr_mode,
   input logic [2*DW-1:0]               ptr_addr,
   input logic [2*DW-1:0]               ds_addr,
   input logic                          ds_we,
   input logic [DW-1:0]                 ds_rdata,
   input logic                          ds_hit_reg,
   input logic [NREGS-1:0][DW-1:0]      regs_q
);

   localparam int unsigned IDXW = $clog2(NREGS);
   localparam int unsigned PW   = 2*DW;
   localparam int unsigned SELW = $clog2(NPTR+1);

   function automatic logic [PW-1:0] pair_val(input logic [NREGS-1:0][DW-1:0] r,
                                               input logic [SELW-1:0] s);
      int lo;
      lo = int'(PTR_BASE) + 2*int'(s);
      return {r[lo+1], r[lo]};
   endfunction

   logic quiet_wr;
   assign quiet_wr = !wr_en && !ds_we;

   // R1
   reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (regs_q == '0));

   // R4
   byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_wide) |=> (regs_q[$past(wr_idx)] == $past(wr_data[DW-1:0])));

   // R5
   odd_pair_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_wide && wr_idx[0] && !ds_we && !ptr_en) |=> $stable(regs_q));

   // R6
   no_ptr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_sel >= SELW'(NPTR)) |-> (ptr_addr == '0));

   // R8
   post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_en && ptr_mode == 2'd2 && ptr_sel < SELW'(NPTR) && quiet_wr)
      |=> (pair_val(regs_q, $past(ptr_sel)) == $past(ptr_addr) + PW'(1)));

   // R9
   pre_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_en && ptr_mode == 2'd3 && ptr_sel < SELW'(NPTR) && quiet_wr)
      |=> (pair_val(regs_q, $past(ptr_sel)) == $past(ptr_addr)));

   // R10
   ds_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_hit_reg && rd_a_idx == ds_addr[IDXW-1:0]) |-> (ds_rdata == rd_a_data));

endmodule

bind rfp_regfile rfp_checker #(
   .DW       (DW),
   .NREGS    (NREGS),
   .PTR_BASE (PTR_BASE),
   .NPTR     (NPTR)
) i_rfp_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_a_idx   (rd_a_idx),
   .rd_a_data  (rd_a_data),
   .wr_en      (wr_en),
   .wr_wide    (wr_wide),
   .wr_idx     (wr_idx),
   .wr_data    (wr_data),
   .ptr_en     (ptr_en),
   .ptr_sel    (ptr_sel),
   .ptr_mode   (ptr_mode),
   .ptr_addr   (ptr_addr),
   .ds_addr    (ds_addr),
   .ds_we      (ds_we),
   .ds_rdata   (ds_rdata),
   .ds_hit_reg (ds_hit_reg),
   .regs_q     (regs_q)
);

// File: tb/test_rfp_regfile.sv
`timescale 1ns/1ps
module test_rfp_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
   logic [7:0]  rd_a_data, rd_b_data, ds_wdata, ds_rdata;
   logic [15:0] rd_w_data, wr_data, ptr_addr, ds_addr;
   logic        wr_en, wr_wide, ptr_en, ds_we, ds_hit_reg, ds_hit_io;
   logic [1:0]  ptr_sel, ptr_mode;
   logic [5:0]  ptr_disp;

   int total = 0;
   int bad   = 0;
   logic [7:0] model [32];

   always #4 clk = ~clk;

   rfp_regfile i_rfp_regfile (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
      .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_w_data(rd_w_data),
      .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
      .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_disp(ptr_disp),
      .ptr_addr(ptr_addr),
      .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
      .ds_rdata(ds_rdata), .ds_hit_reg(ds_hit_reg), .ds_hit_io(ds_hit_io)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [15:0] pair_m(input int s);
      return {model[26+2*s+1], model[26+2*s]};
   endfunction

   function automatic logic [15:0] exp_ptr_addr();
      logic [15:0] p;
      if (ptr_sel == 2'd3) return 16'h0000;
      p = pair_m(int'(ptr_sel));
      case (ptr_mode)
         2'd0:    return p;
         2'd1:    return p + {10'd0, ptr_disp};
         2'd2:    return p;
         default: return p - 16'd1;
      endcase
   endfunction

   function automatic string ptr_tag();
      if (ptr_sel == 2'd3) return "R6";
      if (ptr_mode < 2'd2) return "R7";
      if (ptr_mode == 2'd2) return "R8";
      return "R9";
   endfunction

   task automatic compare_outputs();
      logic hr, hi;
      hr = (ds_addr < 16'h0020);
      hi = (ds_addr >= 16'h0020) && (ds_addr < 16'h0060);
      check("R2 port A", {8'h00, rd_a_data}, {8'h00, model[rd_a_idx]});
      check("R2 port B", {8'h00, rd_b_data}, {8'h00, model[rd_b_idx]});
      check("R3 pair read", rd_w_data, {model[{rd_a_idx[4:1], 1'b1}], model[{rd_a_idx[4:1], 1'b0}]});
      check(ptr_tag(), ptr_addr, exp_ptr_addr());
      check("R10 hit_reg", {15'd0, ds_hit_reg}, {15'd0, hr});
      check("R10 hit_io", {15'd0, ds_hit_io}, {15'd0, hi});
      check("R10 rdata", {8'h00, ds_rdata}, hr ? {8'h00, model[ds_addr[4:0]]} : 16'h0000);
   endtask

   // applies writers lowest priority first (R12)
   task automatic model_update();
      logic [15:0] p, v;
      int lo;
      if (ptr_en && ptr_sel != 2'd3 && ptr_mode[1]) begin
         lo = 26 + 2*int'(ptr_sel);
         p  = pair_m(int'(ptr_sel));
         v  = (ptr_mode == 2'd2) ? p + 16'd1 : p - 16'd1;
         model[lo]   = v[7:0];
         model[lo+1] = v[15:8];
      end
      if (ds_we && ds_addr < 16'h0020) model[ds_addr[4:0]] = ds_wdata;
      if (wr_en) begin
         if (!wr_wide) model[wr_idx] = wr_data[7:0];
         else if (!wr_idx[0]) begin
            model[wr_idx]        = wr_data[7:0];
            model[wr_idx | 5'd1] = wr_data[15:8];
         end
      end
   endtask

   task automatic step();
      #1 compare_outputs();
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic idle();
      wr_en = 0; wr_wide = 0; wr_idx = 0; wr_data = 0;
      ptr_en = 0; ptr_sel = 2'd3; ptr_mode = 0; ptr_disp = 0;
      ds_we = 0; ds_addr = 16'hFFFF; ds_wdata = 0;
      rd_a_idx = 0; rd_b_idx = 0;
   endtask

   task automatic dump(input string tag);
      idle();
      for (int i = 0; i < 32; i++) begin
         rd_a_idx = 5'(i);
         rd_b_idx = 5'(31 - i);
         #1 check(tag, {8'h00, rd_a_data}, {8'h00, model[i]});
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wwide(input logic [4:0] idx, input logic [15:0] val);
      idle();
      wr_en = 1; wr_wide = 1; wr_idx = idx; wr_data = val;
      step();
      idle();
   endtask

   task automatic ptr_op(input logic [1:0] s, input logic [1:0] m, input logic [5:0] d);
      idle();
      ptr_en = 1; ptr_sel = s; ptr_mode = m; ptr_disp = d;
      step();
      idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      dump("R1 reset");

      // R2 and R4: byte write, same-cycle read sees old value
      idle(); wr_en = 1; wr_idx = 5'd5; wr_data = 16'h00A5; rd_a_idx = 5'd5;
      #1 check("R2 same-cycle old", {8'h00, rd_a_data}, 16'h0000);
      step(); idle();
      rd_a_idx = 5'd5;
      #1 check("R4 byte write", {8'h00, rd_a_data}, 16'h00A5);
      @(negedge clk);

      // R5: aligned pair write, odd index ignored; R3 odd index read
      wwide(5'd10, 16'h1234);
      wwide(5'd11, 16'hBEEF);
      rd_a_idx = 5'd11;
      #1 check("R3 odd index pair", rd_w_data, 16'h1234);
      @(negedge clk);
      dump("R5 pair write");

      // R8: post-increment wraps
      wwide(5'd26, 16'hFFFF);
      idle(); ptr_en = 1; ptr_sel = 0; ptr_mode = 2'd2;
      #1 check("R8 address", ptr_addr, 16'hFFFF);
      step(); idle();
      dump("R8 post-inc");
      check("R8 wrap", pair_m(0), 16'h0000);

      // R9: pre-decrement from zero
      idle(); ptr_en = 1; ptr_sel = 1; ptr_mode = 2'd3;
      #1 check("R9 address", ptr_addr, 16'hFFFF);
      step(); idle();
      dump("R9 pre-dec");

      // R7: displacement and plain, no update
      wwide(5'd30, 16'h0100);
      idle(); ptr_en = 1; ptr_sel = 2; ptr_mode = 2'd1; ptr_disp = 6'h3F;
      #1 check("R7 displacement", ptr_addr, 16'h013F);
      step();
      ptr_op(2'd2, 2'd0, 6'h00);
      dump("R7 no update");

      // R6: no pointer selected
      idle(); ptr_en = 1; ptr_sel = 3; ptr_mode = 2'd2;
      #1 check("R6 null address", ptr_addr, 16'h0000);
      step();
      dump("R6 no update");

      // R11: data-space writes in and out of the register window
      idle(); ds_we = 1; ds_addr = 16'h001F; ds_wdata = 8'h77; step();
      idle(); ds_we = 1; ds_addr = 16'h0020; ds_wdata = 8'h99; step();
      idle(); ds_we = 1; ds_addr = 16'h005F; ds_wdata = 8'h98; step();
      idle(); ds_we = 1; ds_addr = 16'h1000; ds_wdata = 8'h97; step();
      dump("R11 data-space write");
      check("R11 r31", {8'h00, model[31]}, 16'h0077);

      // R12: pointer write-back colliding with port and data-space writes
      wwide(5'd26, 16'h00FF);
      idle(); ptr_en = 1; ptr_sel = 0; ptr_mode = 2'd2;
      wr_en = 1; wr_idx = 5'd26; wr_data = 16'h0055;
      ds_we = 1; ds_addr = 16'h001A; ds_wdata = 8'h66;
      step(); idle();
      dump("R12 priority low byte");
      check("R12 pair", pair_m(0), 16'h0155);
      idle(); ptr_en = 1; ptr_sel = 1; ptr_mode = 2'd3;
      ds_we = 1; ds_addr = 16'h001D; ds_wdata = 8'h3C;
      step(); idle();
      dump("R12 priority high byte");

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         idle();
         rd_a_idx = 5'($urandom);
         rd_b_idx = 5'($urandom);
         wr_en    = ($urandom % 2) == 0;
         wr_wide  = ($urandom % 3) == 0;
         wr_idx   = ($urandom % 2) ? 5'(26 + $urandom % 6) : 5'($urandom);
         wr_data  = 16'($urandom);
         ptr_en   = ($urandom % 2) == 0;
         ptr_sel  = 2'($urandom);
         ptr_mode = 2'($urandom);
         ptr_disp = 6'($urandom);
         case ($urandom % 3)
            0:       ds_addr = 16'($urandom % 32);
            1:       ds_addr = 16'(32 + $urandom % 64);
            default: ds_addr = 16'($urandom);
         endcase
         ds_we    = ($urandom % 3) == 0;
         ds_wdata = 8'($urandom);
         step();
      end
      dump("R12 random final");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule